// File: doc/BRIEF.md
# Floating-Point Compare Condition Status Updater

This block keeps the condition part of a 32-bit floating-point status word up to date as compare operations finish. Each compare delivers a two-bit relation (greater, less, equal or unordered) and a five-bit condition mask. The block picks the one mask bit that matches the relation, and that bit is the outcome of the compare.

The outcome is stored in one of two ways, chosen by a target index. With a nonzero index in range, the outcome goes straight into one addressed condition bit and every other bit is kept. With index zero, a ten-deep history of past outcomes shifts down by one place. The current-condition bit then enters the top of that history, and the new outcome becomes the current condition.

Mask bit 0 is passed to the comparator at once as its signaling-or-quiet select. A load port can replace the whole word, for example on a context restore.

Top module: `fpcq_status`

## Requirements
- R1: While `rst` is high at a rising clock edge, `status_word` becomes all zeros.
- R2: The outcome bit is chosen from `cmp_mask` by the relation code on `cmp_rel`: code 0 (greater) takes mask bit 4, code 1 (less) takes bit 3, code 2 (equal) takes bit 2, and code 3 (unordered) takes bit 1.
- R3: `cmp_signaling` equals `cmp_mask[0]` in the same cycle, with no register between them (1 = signaling compare, 0 = quiet compare).
- R4: With `cmp_strobe` high and `cmp_target` = y in 1..10, the next word has the outcome in bit 22−y. All other bits are unchanged.
- R5: With `cmp_strobe` high and `cmp_target` = 0, bits 20 down to 11 of the next word take the previous values of bits 21 down to 12.
- R6: In the same queued update, bit 21 takes the previous value of bit 26, and bit 26 takes the outcome. Bits outside 26 and 21..11 are unchanged.
- R7: With `cmp_strobe` high and `cmp_target` in 11..15, the word is unchanged.
- R8: With `cmp_strobe` and `sw_load` both low, the word is unchanged.
- R9: With `sw_load` high, the next word equals `sw_data`. This holds even if `cmp_strobe` is also high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_strobe | input | 1 | A compare outcome is present this cycle |
| cmp_rel | input | 2 | Relation code: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_mask | input | 5 | Condition mask; bits 4..1 per relation, bit 0 signaling select |
| cmp_target | input | 4 | 0 = queued update, 1..10 = addressed condition bit |
| sw_load | input | 1 | Load the whole word from `sw_data` |
| sw_data | input | 32 | Word to load |
| status_word | output | 32 | Registered status word |
| cmp_signaling | output | 1 | Signaling (1) or quiet (0) compare select to the comparator |

## Verification
The word is registered, so every update (reset, load, targeted, queued or ignored) shows at the port one rising edge after the cycle that presented it. The signaling select is combinational and is due in the cycle its mask is driven. The bench drives its inputs just after each falling edge and checks the select a moment later. After the next rising edge, a behavioural model of the word moves to its new value. The bench compares the port with that model on every falling edge, which is half a period after the design's only register has changed.

// File: rtl/fpcq_pkg.sv
package fpcq_pkg;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Condition mask: field order matters, greater sits at the top bit
    typedef struct packed {
        logic on_gt;
        logic on_lt;
        logic on_eq;
        logic on_un;
        logic signaling;
    } cmask_t;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_TARGET,
        UPD_QUEUE,
        UPD_LOAD
    } upd_e;

    function automatic logic pick_outcome(rel_e rel, cmask_t m);
        logic r;
        case (rel)
            REL_GT:  r = m.on_gt;
            REL_LT:  r = m.on_lt;
            REL_EQ:  r = m.on_eq;
            default: r = m.on_un;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpcq_select.sv
module fpcq_select
    import fpcq_pkg::*;
(
    input  rel_e   rel_i,
    input  cmask_t mask_i,
    output logic   outcome_o,
    output logic   signaling_o
);

    always_comb begin
        outcome_o   = pick_outcome(rel_i, mask_i);
        signaling_o = mask_i.signaling;
    end

endmodule

// File: rtl/fpcq_decode.sv
module fpcq_decode
    import fpcq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int QLEN   = 10,
    parameter int QHEAD  = 21,
    parameter int Y_W    = 4
) (
    input  logic              strobe_i,
    input  logic              load_i,
    input  logic [Y_W-1:0]    target_i,
    output upd_e              kind_o,
    output logic [WORD_W-1:0] sel_o
);

    localparam logic [Y_W-1:0] Y_MAX = Y_W'(QLEN);

    logic in_range;

    assign in_range = (target_i != '0) && (target_i <= Y_MAX);

    always_comb begin
        if (load_i)
            kind_o = UPD_LOAD;
        else if (!strobe_i)
            kind_o = UPD_HOLD;
        else if (target_i == '0)
            kind_o = UPD_QUEUE;
        else if (in_range)
            kind_o = UPD_TARGET;
        else
            kind_o = UPD_HOLD;
    end

    // One-hot pointer onto the addressed condition bit
    generate
        for (genvar k = 1; k <= QLEN; k++) begin : g_sel
            assign sel_o[QHEAD+1-k] = (target_i == Y_W'(k));
        end
        if (QHEAD + 1 < WORD_W) begin : g_hi
            assign sel_o[WORD_W-1:QHEAD+1] = '0;
        end
        if (QHEAD + 1 - QLEN > 0) begin : g_lo
            assign sel_o[QHEAD-QLEN:0] = '0;
        end
    endgenerate

endmodule

// File: rtl/fpcq_next.sv
module fpcq_next
    import fpcq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int QLEN    = 10,
    parameter int QHEAD   = 21,
    parameter int CUR_BIT = 26
) (
    input  upd_e              kind_i,
    input  logic [WORD_W-1:0] cur_i,
    input  logic [WORD_W-1:0] sel_i,
    input  logic              outcome_i,
    input  logic [WORD_W-1:0] load_i,
    output logic [WORD_W-1:0] nxt_o
);

    localparam int QLOW = QHEAD - QLEN;

    logic [WORD_W-1:0] shifted;

    // History shift: each slot takes its upper neighbour
    always_comb begin
        shifted = cur_i;
        for (int i = QLOW; i < QHEAD; i++)
            shifted[i] = cur_i[i+1];
        shifted[QHEAD]   = cur_i[CUR_BIT];
        shifted[CUR_BIT] = outcome_i;
    end

    always_comb begin
        case (kind_i)
            UPD_LOAD:   nxt_o = load_i;
            UPD_TARGET: nxt_o = (cur_i & ~sel_i) | (sel_i & {WORD_W{outcome_i}});
            UPD_QUEUE:  nxt_o = shifted;
            default:    nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/fpcq_status.sv
module fpcq_status
    import fpcq_pkg::*;
#(
    parameter int          WORD_W    = 32,
    parameter int          QLEN      = 10,
    parameter int          QHEAD     = 21,
    parameter int          CUR_BIT   = 26,
    parameter logic [31:0] RESET_VAL = 32'h0,
    localparam int         Y_W       = $clog2(QLEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_strobe,
    input  logic [1:0]        cmp_rel,
    input  logic [4:0]        cmp_mask,
    input  logic [Y_W-1:0]    cmp_target,
    input  logic              sw_load,
    input  logic [WORD_W-1:0] sw_data,
    output logic [WORD_W-1:0] status_word,
    output logic              cmp_signaling
);

    logic              outcome;
    upd_e              kind;
    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] nxt;

    fpcq_select u_select (
        .rel_i       (rel_e'(cmp_rel)),
        .mask_i      (cmask_t'(cmp_mask)),
        .outcome_o   (outcome),
        .signaling_o (cmp_signaling)
    );

    fpcq_decode #(
        .WORD_W (WORD_W),
        .QLEN   (QLEN),
        .QHEAD  (QHEAD),
        .Y_W    (Y_W)
    ) u_decode (
        .strobe_i (cmp_strobe),
        .load_i   (sw_load),
        .target_i (cmp_target),
        .kind_o   (kind),
        .sel_o    (sel)
    );

    fpcq_next #(
        .WORD_W  (WORD_W),
        .QLEN    (QLEN),
        .QHEAD   (QHEAD),
        .CUR_BIT (CUR_BIT)
    ) u_next (
        .kind_i    (kind),
        .cur_i     (status_word),
        .sel_i     (sel),
        .outcome_i (outcome),
        .load_i    (sw_data),
        .nxt_o     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            status_word <= RESET_VAL[WORD_W-1:0];
        else
            status_word <= nxt;
    end

    // R8: idle cycles keep the word
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmp_strobe && !sw_load) |=> $stable(status_word));

    // R9: load wins and lands one edge later
    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        sw_load |=> (status_word == $past(sw_data)));

    // R7: out-of-range index is ignored
    p_range_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && !sw_load && cmp_target > Y_W'(QLEN)) |=> $stable(status_word));

    // R4: addressed write touches only its own bit
    p_target_only_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && !sw_load && cmp_target != '0 && cmp_target <= Y_W'(QLEN)) |=>
        (((status_word ^ $past(status_word)) &
          ~(WORD_W'(1) << (QHEAD + 1 - int'($past(cmp_target))))) == '0));

    // R5: history slides down by one place
    p_queue_slide_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && !sw_load && cmp_target == '0) |=>
        (status_word[QHEAD-1:QHEAD-QLEN] == $past(status_word[QHEAD:QHEAD-QLEN+1])));

    // R6: old current condition enters the history head
    p_queue_head_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && !sw_load && cmp_target == '0) |=>
        (status_word[QHEAD] == $past(status_word[CUR_BIT])));

endmodule

// File: tb/fpcq_status_tb.sv
module fpcq_status_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_strobe = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_mask = '0;
    logic [3:0]  cmp_target = '0;
    logic        sw_load = 1'b0;
    logic [31:0] sw_data = '0;
    logic [31:0] status_word;
    logic        cmp_signaling;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_word;
    string       exp_tag = "R1";

    always #4 clk = ~clk;

    fpcq_status u_dut (
        .clk           (clk),
        .rst           (rst),
        .cmp_strobe    (cmp_strobe),
        .cmp_rel       (cmp_rel),
        .cmp_mask      (cmp_mask),
        .cmp_target    (cmp_target),
        .sw_load       (sw_load),
        .sw_data       (sw_data),
        .status_word   (status_word),
        .cmp_signaling (cmp_signaling)
    );

    // Behavioural reference of the word
    always @(posedge clk) begin
        logic [31:0] t;
        logic        c;
        if (rst) begin
            exp_word = 32'h0;
            exp_tag  = "R1 reset";
        end else if (sw_load) begin
            exp_word = sw_data;
            exp_tag  = cmp_strobe ? "R9 load over strobe" : "R9 load";
        end else if (cmp_strobe) begin
            c = cmp_mask[4 - cmp_rel];
            if (cmp_target == 0) begin
                t = exp_word;
                for (int i = 11; i <= 20; i++) t[i] = exp_word[i+1];
                t[21] = exp_word[26];
                t[26] = c;
                exp_word = t;
                exp_tag  = "R5 R6 R2 queued";
            end else if (cmp_target <= 10) begin
                exp_word[22 - cmp_target] = c;
                exp_tag = "R4 R2 targeted";
            end else begin
                exp_tag = "R7 out of range";
            end
        end else begin
            exp_tag = "R8 idle";
        end
    end

    task automatic check_word();
        checks++;
        if (status_word !== exp_word) begin
            errors++;
            $display("FAIL %s: status_word=%h expected %h", exp_tag, status_word, exp_word);
        end
    endtask

    task automatic drive(input logic s, input logic [1:0] r, input logic [4:0] m,
                         input logic [3:0] y, input logic ld, input logic [31:0] d);
        cmp_strobe = s; cmp_rel = r; cmp_mask = m; cmp_target = y;
        sw_load = ld; sw_data = d;
        #1;
        checks++;
        if (cmp_signaling !== m[0]) begin
            errors++;
            $display("FAIL R3: cmp_signaling=%b expected %b", cmp_signaling, m[0]);
        end
        @(negedge clk);
        check_word();
    endtask

    initial begin : watchdog
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_word();                                  // R1
        rst = 1'b0;
        // R2/R4: each relation into addressed bits
        drive(1, 2'd0, 5'b10000, 4'd1, 0, '0);         // bit 21 <= 1
        drive(1, 2'd1, 5'b01000, 4'd2, 0, '0);         // bit 20 <= 1
        drive(1, 2'd2, 5'b00100, 4'd3, 0, '0);         // bit 19 <= 1
        drive(1, 2'd3, 5'b00010, 4'd10, 0, '0);        // bit 12 <= 1
        drive(1, 2'd0, 5'b01111, 4'd2, 0, '0);         // bit 20 <= 0
        // R5/R6: queued pushes
        drive(1, 2'd2, 5'b00101, 4'd0, 0, '0);
        drive(1, 2'd1, 5'b10110, 4'd0, 0, '0);
        drive(1, 2'd3, 5'b00010, 4'd0, 0, '0);
        // R7: out of range
        drive(1, 2'd0, 5'b11111, 4'd11, 0, '0);
        drive(1, 2'd3, 5'b11111, 4'd15, 0, '0);
        // R8: idle
        drive(0, 2'd0, 5'b11111, 4'd1, 0, '0);
        // R9: load alone and against a strobe
        drive(0, 2'd0, 5'b00000, 4'd0, 1, 32'hA5A5_F00F);
        drive(1, 2'd0, 5'b10001, 4'd0, 1, 32'h0400_1800);
        drive(1, 2'd0, 5'b10000, 4'd0, 0, '0);
        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            drive($urandom_range(0, 3) != 0, 2'($urandom), 5'($urandom),
                  4'($urandom_range(0, 13)), $urandom_range(0, 30) == 0, $urandom);
        end
        // R1: reset from a busy word
        rst = 1'b1;
        @(negedge clk);
        check_word();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule